// File: doc/BRIEF.md
# SDRAM Command and Refresh Sequencer

This block issues the housekeeping commands that a single-data-rate SDRAM needs before and between data transfers. A host writes three 32-bit registers over a plain write/read port: a control register whose low bits each launch one command, a mode configuration register holding a compact burst-length and CAS-latency code, and a refresh register holding a period and an enable. From these the block drives the chip-select, row-strobe, column-strobe, write-enable, clock-enable, address and bank lines. Software steps the device's start-up sequence one command at a time (precharge all, auto-refresh, load mode). Each trigger bit flips its read-back value whenever its command goes out, so software can tell that the command was issued.

A periodic timer adds auto-refresh commands without software help. A fixed minimum gap is kept after every command. Simultaneous requests are served in a fixed order. The block can also put the device into self-refresh or power-down by controlling the clock-enable line. The compact mode code is translated into the standard mode-register word on the address lines. Data transfers and address mapping belong to other blocks.

Top module: `sdr_cmd_seq`

## Requirements
- R1: After reset the control register (index 0) reads 0, the config register (index 1) reads 0, the refresh register (index 2) reads 0x0000_8040, the pins carry NOP (all four strobes high) and clock enable is high.
- R2: Writing 1 to control bit 0, 1 or 2 issues exactly one command: auto-refresh (strobes CS,RAS,CAS,WE = 0,0,0,1), precharge (0,0,1,0) or load-mode (0,0,0,0). The read-back of that bit toggles once per command issued from that bit. Timer refreshes do not toggle it.
- R3: A load-mode command drives the address with {CAS code in A6:A4, 0 in A3, burst code in A2:A0} and every higher bit 0. Config bits 1:0 select the burst code: 00→111, 01→011, 10→010, 11→001. Config bit 2 selects the CAS code: 0→011, 1→010. The bank lines are 0.
- R4: A precharge command drives A10 high and every other address bit low.
- R5: Chip select is low for exactly one clock per command. In every other cycle the pins carry NOP.
- R6: After an auto-refresh the next command comes no sooner than 7 clocks later. After a precharge or a load-mode it comes no sooner than 2 clocks later.
- R7: When several requests wait at once they issue in this order: software refresh, precharge, load-mode, timer refresh.
- R8: With refresh bit 15 set and period P = bits 7:0 non-zero, the timer issues one auto-refresh every 16·P clocks. P = 0, or bit 15 clear, produces no periodic refresh.
- R9: Setting control bit 8 issues one self-refresh entry (auto-refresh strobes with clock enable low). Clock enable stays low and the periodic timer is paused while the bit stays set.
- R10: Clearing bit 8 raises clock enable and starts a 7-clock gap. The next command comes exactly 7 clocks after clock enable rises.
- R11: With control bit 9 set, clock enable goes low while no command is pending or in its gap. It is high in the cycle a command is issued.
- R12: Writing 1 to control bit 7 returns every register, pending request and the timer to the R1 state. Any trigger bits in that same write are dropped, and bit 7 reads 0.
- R13: Control bits 3, 5:4, 10 and 11 are stored and read back at those positions without side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_waddr | input | 2 | Write register index (0 control, 1 config, 2 refresh) |
| host_wdata | input | 32 | Write data |
| host_raddr | input | 2 | Read register index |
| host_rdata | output | 32 | Read data (combinational) |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | SDRAM address lines |
| sd_ba | output | BA_W | SDRAM bank lines |

## Verification
The mode-word translation is driven through all eight config codes. This separates every burst code from every CAS code and catches a swapped or shifted field. A single write with three trigger bits set exposes both the service order and the exact gaps, since a wrong order or a gap off by one moves the measured cycle distances. The timer is run with a short period to measure the exact interval, and with a zero period and with refresh disabled to show suppression. Self-refresh, power-down and soft reset are each followed by a trigger so that the exit gap, the clock-enable behaviour and the dropped trigger can be seen at the pins.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    localparam int HOST_W = 32;
    localparam int RA_W   = 2;

    localparam logic [RA_W-1:0] RA_CTRL = 2'd0;
    localparam logic [RA_W-1:0] RA_CFG  = 2'd1;
    localparam logic [RA_W-1:0] RA_RFSH = 2'd2;

    // control register bit positions
    localparam int B_TRG_REF = 0;
    localparam int B_TRG_PRE = 1;
    localparam int B_TRG_MRS = 2;
    localparam int B_EN      = 3;
    localparam int B_DENS    = 4;
    localparam int B_SRST    = 7;
    localparam int B_SELF    = 8;
    localparam int B_PDN     = 9;
    localparam int B_W32     = 10;
    localparam int B_COL9    = 11;
    localparam int B_RFSH_EN = 15;

    localparam int A_PRE_ALL = 10;
    localparam int MODE_W    = 7;

    localparam logic [7:0] RFSH_PERIOD_RST = 8'h40;

    localparam logic [2:0] GAP_REF = 3'd7;
    localparam logic [2:0] GAP_PRE = 3'd2;
    localparam logic [2:0] GAP_MRS = 3'd2;

    typedef enum logic [2:0] {
        K_NONE, K_REF, K_PRE, K_MRS, K_TREF, K_SRE
    } cmd_kind_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    localparam pins_t PINS_NOP = 4'b1111;
    localparam pins_t PINS_REF = 4'b0001;
    localparam pins_t PINS_PRE = 4'b0010;
    localparam pins_t PINS_MRS = 4'b0000;

    typedef struct packed {
        logic       col9;
        logic       bus32;
        logic       pwrdn;
        logic       selfref;
        logic [1:0] density;
        logic       en;
    } ctrl_t;

    function automatic pins_t pins_of(cmd_kind_e k);
        case (k)
            K_REF, K_TREF, K_SRE: return PINS_REF;
            K_PRE:                return PINS_PRE;
            K_MRS:                return PINS_MRS;
            default:              return PINS_NOP;
        endcase
    endfunction

    function automatic logic [2:0] gap_of(cmd_kind_e k);
        case (k)
            K_REF, K_TREF: return GAP_REF;
            K_PRE:         return GAP_PRE;
            K_MRS:         return GAP_MRS;
            default:       return 3'd0;
        endcase
    endfunction

    // compact config code -> standard mode-register word
    function automatic logic [MODE_W-1:0] mode_word(logic [1:0] bl_sel, logic cl_two);
        logic [2:0] bl;
        logic [2:0] cl;
        case (bl_sel)
            2'b00:   bl = 3'b111;
            2'b01:   bl = 3'b011;
            2'b10:   bl = 3'b010;
            default: bl = 3'b001;
        endcase
        cl = cl_two ? 3'b010 : 3'b011;
        return {cl, 1'b0, bl};
    endfunction

endpackage

// File: rtl/sdr_host_regs.sv
module sdr_host_regs
    import sdr_seq_pkg::*;
#(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [RA_W-1:0]     wr_addr,
    input  logic [HOST_W-1:0]   wr_data,
    input  logic [RA_W-1:0]     rd_addr,
    output logic [HOST_W-1:0]   rd_data,
    input  logic                gnt_ref,
    input  logic                gnt_pre,
    input  logic                gnt_mrs,
    output logic                soft_clr,
    output logic                pend_ref,
    output logic                pend_pre,
    output logic                pend_mrs,
    output ctrl_t               ctrl,
    output logic [1:0]          burst_sel,
    output logic                cas_two,
    output logic [PERIOD_W-1:0] period,
    output logic                ref_en,
    output logic                rfsh_wr_q
);

    ctrl_t               ctrl_q;
    logic [2:0]          tog_q;
    logic [2:0]          pend_q;
    logic [2:0]          cfg_q;
    logic [PERIOD_W-1:0] per_q;
    logic                ren_q;

    logic       wr_ctrl, wr_cfg, wr_rfsh;
    logic [2:0] gnt_v, trg_v;
    logic       unused_wr_bits;

    assign wr_ctrl  = wr_en && (wr_addr == RA_CTRL);
    assign wr_cfg   = wr_en && (wr_addr == RA_CFG);
    assign wr_rfsh  = wr_en && (wr_addr == RA_RFSH);
    assign soft_clr = wr_ctrl && wr_data[B_SRST];
    assign gnt_v    = {gnt_mrs, gnt_pre, gnt_ref};
    assign trg_v    = wr_ctrl ? {wr_data[B_TRG_MRS], wr_data[B_TRG_PRE], wr_data[B_TRG_REF]} : 3'b000;
    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            ctrl_q    <= '0;
            tog_q     <= '0;
            pend_q    <= '0;
            cfg_q     <= '0;
            per_q     <= PERIOD_W'(RFSH_PERIOD_RST);
            ren_q     <= 1'b1;
            rfsh_wr_q <= 1'b0;
        end else begin
            tog_q     <= tog_q ^ gnt_v;
            pend_q    <= (pend_q & ~gnt_v) | trg_v;
            rfsh_wr_q <= wr_rfsh;
            if (wr_ctrl) begin
                ctrl_q.col9    <= wr_data[B_COL9];
                ctrl_q.bus32   <= wr_data[B_W32];
                ctrl_q.pwrdn   <= wr_data[B_PDN];
                ctrl_q.selfref <= wr_data[B_SELF];
                ctrl_q.density <= wr_data[B_DENS +: 2];
                ctrl_q.en      <= wr_data[B_EN];
            end
            if (wr_cfg)
                cfg_q <= wr_data[2:0];
            if (wr_rfsh) begin
                per_q <= wr_data[PERIOD_W-1:0];
                ren_q <= wr_data[B_RFSH_EN];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTRL: begin
                rd_data[B_TRG_REF]   = tog_q[0];
                rd_data[B_TRG_PRE]   = tog_q[1];
                rd_data[B_TRG_MRS]   = tog_q[2];
                rd_data[B_EN]        = ctrl_q.en;
                rd_data[B_DENS +: 2] = ctrl_q.density;
                rd_data[B_SELF]      = ctrl_q.selfref;
                rd_data[B_PDN]       = ctrl_q.pwrdn;
                rd_data[B_W32]       = ctrl_q.bus32;
                rd_data[B_COL9]      = ctrl_q.col9;
            end
            RA_CFG:  rd_data[2:0] = cfg_q;
            RA_RFSH: begin
                rd_data[PERIOD_W-1:0] = per_q;
                rd_data[B_RFSH_EN]    = ren_q;
            end
            default: rd_data = '0;
        endcase
    end

    assign pend_ref  = pend_q[0];
    assign pend_pre  = pend_q[1];
    assign pend_mrs  = pend_q[2];
    assign ctrl      = ctrl_q;
    assign burst_sel = cfg_q[1:0];
    assign cas_two   = cfg_q[2];
    assign period    = per_q;
    assign ref_en    = ren_q;

    // R2: a granted software refresh leaves no request behind unless re-triggered
    a_r2_pend_drop: assert property (@(posedge clk) disable iff (rst || soft_clr)
        (gnt_ref && !(wr_ctrl && wr_data[B_TRG_REF])) |=> !pend_ref);

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer
    import sdr_seq_pkg::*;
#(
    parameter int PERIOD_W  = 8,
    parameter int UNIT_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [PERIOD_W-1:0] period,
    input  logic                enable,
    input  logic                hold,
    input  logic                reload,
    input  logic                gnt,
    output logic                req
);

    localparam int CNT_W = PERIOD_W + UNIT_LOG2;
    localparam logic [UNIT_LOG2-1:0] UNIT_ZERO = '0;
    localparam logic [CNT_W-1:0] RST_LOAD =
        (CNT_W'(RFSH_PERIOD_RST) << UNIT_LOG2) - CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_val;
    logic             live;
    logic             req_q;

    assign reload_val = {period, UNIT_ZERO} - CNT_W'(1);
    assign live       = enable && (period != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= RST_LOAD;
            req_q <= 1'b0;
        end else begin
            if (gnt)
                req_q <= 1'b0;
            if (reload || !live) begin
                cnt_q <= reload_val;
            end else if (!hold) begin
                if (cnt_q == '0) begin
                    req_q <= 1'b1;
                    cnt_q <= reload_val;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assign req = req_q;

    // R9: the timer does not advance while self-refresh holds it
    a_r9_timer_paused: assert property (@(posedge clk) disable iff (rst || clr)
        (hold && live && !reload) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/sdr_cmd_arbiter.sv
module sdr_cmd_arbiter
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              req_ref,
    input  logic              req_pre,
    input  logic              req_mrs,
    input  logic              req_tref,
    input  logic              sr_req,
    input  logic              pd_req,
    input  logic [MODE_W-1:0] mode,
    output logic              gnt_ref,
    output logic              gnt_pre,
    output logic              gnt_mrs,
    output logic              gnt_tref,
    output logic              sr_active,
    output pins_t             pins,
    output logic              cke,
    output logic [ADDR_W-1:0] addr
);

    cmd_kind_e         pick;
    pins_t             pins_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mode_addr, pre_addr;
    logic              cke_q, sr_on, sr_exit, idle, is_cmd;
    logic [2:0]        gap_q;
    logic [2:0]        since_q, need_q;   // checker state for the gap rule

    assign mode_addr = ADDR_W'(mode);
    assign pre_addr  = ADDR_W'(1) << A_PRE_ALL;
    assign sr_exit   = sr_on && !sr_req;
    assign idle      = !(req_ref || req_pre || req_mrs || req_tref) && (gap_q == '0) && !sr_req;

    always_comb begin
        pick = K_NONE;
        if (!sr_on && gap_q == '0) begin
            if (req_ref)       pick = K_REF;
            else if (req_pre)  pick = K_PRE;
            else if (req_mrs)  pick = K_MRS;
            else if (req_tref) pick = K_TREF;
            else if (sr_req)   pick = K_SRE;
        end
    end

    assign is_cmd   = (pick == K_REF) || (pick == K_PRE) || (pick == K_MRS) || (pick == K_TREF);
    assign gnt_ref  = (pick == K_REF);
    assign gnt_pre  = (pick == K_PRE);
    assign gnt_mrs  = (pick == K_MRS);
    assign gnt_tref = (pick == K_TREF);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pins_q  <= PINS_NOP;
            addr_q  <= '0;
            cke_q   <= 1'b1;
            sr_on   <= 1'b0;
            gap_q   <= '0;
            since_q <= 3'd7;
            need_q  <= '0;
        end else begin
            pins_q <= pins_of(pick);
            case (pick)
                K_MRS:   addr_q <= mode_addr;
                K_PRE:   addr_q <= pre_addr;
                default: addr_q <= '0;
            endcase

            if (sr_exit) begin
                sr_on <= 1'b0;
                cke_q <= 1'b1;
                gap_q <= GAP_REF - 3'd1;
            end else if (pick == K_SRE) begin
                sr_on <= 1'b1;
                cke_q <= 1'b0;
            end else if (sr_on) begin
                cke_q <= 1'b0;
            end else begin
                cke_q <= !(pd_req && idle);
                if (is_cmd)
                    gap_q <= gap_of(pick) - 3'd1;
                else if (gap_q != '0)
                    gap_q <= gap_q - 3'd1;
            end

            if (sr_exit) begin
                since_q <= 3'd1;
                need_q  <= GAP_REF;
            end else if (pick != K_NONE) begin
                since_q <= 3'd1;
                need_q  <= gap_of(pick);
            end else if (since_q != 3'd7) begin
                since_q <= since_q + 3'd1;
            end
        end
    end

    assign pins      = pins_q;
    assign cke       = cke_q;
    assign addr      = addr_q;
    assign sr_active = sr_on;

    // R5: chip select never stays low into the next cycle
    a_r5_cs_single: assert property (@(posedge clk) disable iff (rst || clr)
        !pins_q.cs_n |=> pins_q.cs_n);

    // R6 / R10: spacing since the previous command or self-refresh exit
    a_r6_min_gap: assert property (@(posedge clk) disable iff (rst || clr)
        is_cmd |-> (since_q >= need_q));

    // R7: timer refresh only wins when no software request waits
    a_r7_timer_last: assert property (@(posedge clk) disable iff (rst || clr)
        gnt_tref |-> !(req_ref || req_pre || req_mrs));

    // R3: a load-mode word never spills above A6
    a_r3_mode_upper_zero: assert property (@(posedge clk) disable iff (rst || clr)
        (pins_q == PINS_MRS) |-> (addr_q[ADDR_W-1:MODE_W] == '0));

endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2,
    parameter int PERIOD_W  = 8,
    parameter int UNIT_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [1:0]        host_waddr,
    input  logic [31:0]       host_wdata,
    input  logic [1:0]        host_raddr,
    output logic [31:0]       host_rdata,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba
);

    logic                soft_clr;
    logic                pend_ref, pend_pre, pend_mrs, tref_req;
    logic                gnt_ref, gnt_pre, gnt_mrs, gnt_tref;
    logic                sr_active, rfsh_wr_q, ref_en, cas_two;
    logic [1:0]          burst_sel;
    logic [PERIOD_W-1:0] period;
    ctrl_t               ctrl;
    pins_t               pins;

    sdr_host_regs #(.PERIOD_W(PERIOD_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (host_wr),
        .wr_addr   (host_waddr),
        .wr_data   (host_wdata),
        .rd_addr   (host_raddr),
        .rd_data   (host_rdata),
        .gnt_ref   (gnt_ref),
        .gnt_pre   (gnt_pre),
        .gnt_mrs   (gnt_mrs),
        .soft_clr  (soft_clr),
        .pend_ref  (pend_ref),
        .pend_pre  (pend_pre),
        .pend_mrs  (pend_mrs),
        .ctrl      (ctrl),
        .burst_sel (burst_sel),
        .cas_two   (cas_two),
        .period    (period),
        .ref_en    (ref_en),
        .rfsh_wr_q (rfsh_wr_q)
    );

    sdr_refresh_timer #(.PERIOD_W(PERIOD_W), .UNIT_LOG2(UNIT_LOG2)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (soft_clr),
        .period (period),
        .enable (ref_en),
        .hold   (ctrl.selfref || sr_active),
        .reload (rfsh_wr_q),
        .gnt    (gnt_tref),
        .req    (tref_req)
    );

    sdr_cmd_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .clr       (soft_clr),
        .req_ref   (pend_ref),
        .req_pre   (pend_pre),
        .req_mrs   (pend_mrs),
        .req_tref  (tref_req),
        .sr_req    (ctrl.selfref),
        .pd_req    (ctrl.pwrdn),
        .mode      (mode_word(burst_sel, cas_two)),
        .gnt_ref   (gnt_ref),
        .gnt_pre   (gnt_pre),
        .gnt_mrs   (gnt_mrs),
        .gnt_tref  (gnt_tref),
        .sr_active (sr_active),
        .pins      (pins),
        .cke       (sd_cke),
        .addr      (sd_addr)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;
    assign sd_ba    = '0;

endmodule

// File: tb/sim_sdr_cmd_seq.sv
module sim_sdr_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;

    // {config code, expected address word on load-mode}
    localparam logic [15:0] MODE_VEC [8] = '{
        {3'd0, 13'h037}, {3'd1, 13'h033}, {3'd2, 13'h032}, {3'd3, 13'h031},
        {3'd4, 13'h027}, {3'd5, 13'h023}, {3'd6, 13'h022}, {3'd7, 13'h021}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_wr = 1'b0;
    logic [1:0]        host_waddr = '0;
    logic [31:0]       host_wdata = '0;
    logic [1:0]        host_raddr = '0;
    logic [31:0]       host_rdata;
    logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [BA_W-1:0]   sd_ba;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, n_ref = 0, n_pre = 0, n_mrs = 0, n_sre = 0, n_bad = 0, multi_cs = 0;
    int last_ref_cyc = 0, last_pre_cyc = 0, last_mrs_cyc = 0, cke_rise_cyc = 0;
    logic [ADDR_W-1:0] last_pre_addr = '0, last_mrs_addr = '0;
    logic [BA_W-1:0]   last_ba = '0;
    logic prev_cke = 1'b1, prev_cs_low = 1'b0;
    logic [2:0] tog = '0;
    logic [31:0] rd;
    bit done = 0;

    sdr_cmd_seq u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // pin monitor, sampled shortly after each rising edge
    always @(posedge clk) begin
        #2;
        cyc++;
        if (!prev_cke && sd_cke) cke_rise_cyc = cyc;
        prev_cke = sd_cke;
        if (!sd_cs_n) begin
            if (prev_cs_low) multi_cs++;
            last_ba = sd_ba;
            case ({sd_ras_n, sd_cas_n, sd_we_n})
                3'b001: if (sd_cke) begin n_ref++; last_ref_cyc = cyc; end
                        else n_sre++;
                3'b010: begin n_pre++; last_pre_cyc = cyc; last_pre_addr = sd_addr; end
                3'b000: begin n_mrs++; last_mrs_cyc = cyc; last_mrs_addr = sd_addr; end
                default: n_bad++;
            endcase
        end
        prev_cs_low = !sd_cs_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic hr(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_raddr = a;
        #1 d = host_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n0, n1, c1, c2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        idle(2);

        // R1 reset state
        chk("R1 cs_n", {31'b0, sd_cs_n}, 32'd1);
        chk("R1 strobes", {29'b0, sd_ras_n, sd_cas_n, sd_we_n}, 32'd7);
        chk("R1 cke", {31'b0, sd_cke}, 32'd1);
        hr(2'd0, rd); chk("R1 ctrl", rd, 32'h0);
        hr(2'd1, rd); chk("R1 cfg", rd, 32'h0);
        hr(2'd2, rd); chk("R1 refresh", rd, 32'h0000_8040);

        hw(2'd2, 32'h0);   // timer off for directed tests

        // R3/R2 mode-word table
        for (int i = 0; i < 8; i++) begin
            n0 = n_mrs;
            hw(2'd1, {29'b0, MODE_VEC[i][15:13]});
            hw(2'd0, 32'h4);
            tog[2] = ~tog[2];
            idle(12);
            chk("R2 one load-mode", n_mrs, n0 + 1);
            chk("R3 mode word", {19'b0, last_mrs_addr}, {19'b0, MODE_VEC[i][12:0]});
            chk("R3 bank zero", {30'b0, last_ba}, 32'h0);
            hr(2'd0, rd); chk("R2 toggle bit2", rd & 32'h7, {29'b0, tog});
        end

        // R7 order, R6 gaps, R4 precharge address
        n0 = n_ref; n1 = n_pre;
        hw(2'd0, 32'h7);
        tog = tog ^ 3'b111;
        idle(20);
        chk("R2 one refresh", n_ref, n0 + 1);
        chk("R2 one precharge", n_pre, n1 + 1);
        chk("R7 precharge after refresh", (last_pre_cyc > last_ref_cyc), 32'd1);
        chk("R6 gap after refresh", last_pre_cyc - last_ref_cyc, 32'd7);
        chk("R6 gap after precharge", last_mrs_cyc - last_pre_cyc, 32'd2);
        chk("R4 precharge all", {19'b0, last_pre_addr}, 32'h400);
        hr(2'd0, rd); chk("R2 toggle bits", rd & 32'h7, {29'b0, tog});

        // R8 timer interval and suppression
        hw(2'd2, 32'h8002);
        n0 = n_ref;
        for (int k = 0; k < 200 && n_ref < n0 + 1; k++) idle(1);
        c1 = last_ref_cyc;
        for (int k = 0; k < 200 && n_ref < n0 + 2; k++) idle(1);
        c2 = last_ref_cyc;
        chk("R8 timer interval", c2 - c1, 32'd32);
        hr(2'd0, rd); chk("R2 timer keeps toggles", rd & 32'h7, {29'b0, tog});
        hw(2'd2, 32'h8000);
        idle(40); n1 = n_ref; idle(200);
        chk("R8 period zero", n_ref, n1);
        hw(2'd2, 32'h0002);
        idle(40); n1 = n_ref; idle(200);
        chk("R8 disabled", n_ref, n1);

        // R9 self-refresh entry and pause
        hw(2'd2, 32'h8001);
        n0 = n_sre;
        hw(2'd0, 32'h100);
        for (int k = 0; k < 80 && n_sre == n0; k++) idle(1);
        idle(3);
        chk("R9 one entry", n_sre, n0 + 1);
        chk("R9 cke low", {31'b0, sd_cke}, 32'd0);
        n1 = n_ref; idle(100);
        chk("R9 timer paused", n_ref, n1);
        chk("R9 no repeat entry", n_sre, n0 + 1);
        hw(2'd2, 32'h0);

        // R10 exit then gap
        n1 = n_ref;
        hw(2'd0, 32'h001);
        tog[0] = ~tog[0];
        idle(20);
        chk("R10 refresh after exit", n_ref, n1 + 1);
        chk("R10 exit gap", last_ref_cyc - cke_rise_cyc, 32'd7);

        // R11 power-down
        hw(2'd0, 32'h200);
        idle(6);
        chk("R11 cke low idle", {31'b0, sd_cke}, 32'd0);
        n1 = n_ref;
        hw(2'd0, 32'h201);
        tog[0] = ~tog[0];
        idle(4);
        chk("R11 refresh with cke high", n_ref, n1 + 1);
        idle(15);
        chk("R11 cke low again", {31'b0, sd_cke}, 32'd0);
        hw(2'd0, 32'h0);
        idle(3);
        chk("R11 cke high after clear", {31'b0, sd_cke}, 32'd1);

        // R13 stored fields
        n1 = n_ref + n_pre + n_mrs;
        hw(2'd0, 32'h0000_0C38);
        idle(10);
        hr(2'd0, rd); chk("R13 readback", rd, 32'h0000_0C38 | {29'b0, tog});
        chk("R13 no command", n_ref + n_pre + n_mrs, n1);

        // R12 soft reset
        hw(2'd1, 32'h5);
        hw(2'd2, 32'h0003);
        n1 = n_ref;
        hw(2'd0, 32'h81);
        hr(2'd0, rd); chk("R12 ctrl", rd, 32'h0);
        hr(2'd1, rd); chk("R12 cfg", rd, 32'h0);
        hr(2'd2, rd); chk("R12 refresh", rd, 32'h0000_8040);
        idle(30);
        chk("R12 trigger dropped", n_ref, n1);

        // R5 single-cycle commands overall
        chk("R5 cs single cycle", multi_cs, 32'd0);
        chk("R5 only legal commands", n_bad, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule